// File: doc/BRIEF.md
# Memory Error Aggregator with Correctable-Error Threshold Interrupt

This block gathers error reports from a memory read path and presents them to software through a small register window. Each report arrives as a one-cycle pulse from one of two requesters, the processor or the DMA engine. A pulse carries the failing 32-bit address and a class bit that marks it correctable or uncorrectable. For each class the block keeps one sticky flag per requester and one captured address per requester.

Every correctable report also increments a saturating counter. When a counted report brings the counter to or above a programmable 16-bit threshold, a latched interrupt flag is set. That flag drives the interrupt output only while the enable bit is 1. Software can also force the flag or clear it.

Registers that affect the uncorrectable class or the interrupt logic can only be written while the write-unlock input is high. Register reads are combinational: `bus_rdata` returns the addressed register while `bus_rd` is high.

Top module: `mem_err_agg`

## Requirements
- R1: Uncorrectable flags read at offset 0x00 and correctable flags read at offset 0x20. In both, bit 0 is the processor flag and bit 1 is the DMA flag. A matching error pulse sets its flag one cycle later, and the flag stays set until it is cleared.
- R2: Writing 1 to a bit sets the matching flag through the set registers (0x02 uncorrectable, 0x22 correctable). Writing 1 to a bit clears it through the clear registers (0x04, 0x24). The set and clear registers always read 0.
- R3: Four registers capture the failing address: 0x06 uncorrectable processor, 0x08 uncorrectable DMA, 0x26 correctable processor, 0x28 correctable DMA. Each holds the address of the most recent error of its class and requester.
- R4: The counter at 0x30 grows by the number of correctable pulses in a cycle (0, 1 or 2). It saturates at all-ones of its CNT_W-bit width and reads zero-extended.
- R5: The threshold at 0x32 holds bits [15:0]. Bits [31:16] read as 0.
- R6: The interrupt flag at 0x34 bit 0 sets in the cycle after a counted correctable pulse makes the counter greater than or equal to the threshold. Writing 1 to bit 0 of 0x36 clears the flag and writing 1 to bit 0 of 0x38 sets it. A counted pulse wins over a clear in the same cycle.
- R7: `ce_irq` is high exactly when the interrupt flag and the enable bit (0x3A bit 0) are both 1.
- R8: Writes to 0x02, 0x04, 0x32, 0x36, 0x38 and 0x3A take effect only while `wr_unlock` is 1. Writes to 0x22 and 0x24 do not depend on `wr_unlock`.
- R9: After reset every register reads 0. Reserved bits and unlisted offsets read 0, and writes to them change nothing.
- R10: An error pulse that arrives in the same cycle as a software clear of the same flag leaves the flag set.
- R11: `bus_rdata` is 0 while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| wr_unlock | input | 1 | Enables writes to protected registers |
| cpu_err_vld | input | 1 | Processor read error pulse |
| cpu_err_unc | input | 1 | Processor error is uncorrectable (1) or correctable (0) |
| cpu_err_addr | input | 32 | Processor failing address |
| dma_err_vld | input | 1 | DMA read error pulse |
| dma_err_unc | input | 1 | DMA error is uncorrectable (1) or correctable (0) |
| dma_err_addr | input | 32 | DMA failing address |
| ce_irq | output | 1 | Correctable-threshold interrupt |

## Verification
Directed cases cover the patterns that separate look-alike faults:
- A single processor correctable pulse followed by a simultaneous pair from both requesters separates counting by one from counting by the number of events.
- A clear written in the same cycle as an error shows whether the hardware event keeps priority.
- Counting up to the threshold shows whether the compare is greater-or-equal rather than greater-than.
- Long bursts of paired events drive the counter into saturation.
- Locked and unlocked writes to every protected offset show which registers are gated.

Seeded random traffic then mixes pulses of both classes with random writes. It checks `ce_irq` every cycle and reads back all registers periodically against a model kept by the bench.

// File: rtl/mem_err_pkg.sv
package mem_err_pkg;

    localparam int REG_W  = 32;
    localparam int BUS_AW = 6;
    localparam int ERR_AW = 32;
    localparam int THR_W  = 16;
    localparam int REQ_N  = 2;
    localparam int REQ_CPU = 0;
    localparam int REQ_DMA = 1;

    // Register offsets (byte addresses)
    localparam logic [BUS_AW-1:0] OFS_UC_FLAG  = 6'h00;
    localparam logic [BUS_AW-1:0] OFS_UC_SET   = 6'h02;
    localparam logic [BUS_AW-1:0] OFS_UC_CLR   = 6'h04;
    localparam logic [BUS_AW-1:0] OFS_UC_ACPU  = 6'h06;
    localparam logic [BUS_AW-1:0] OFS_UC_ADMA  = 6'h08;
    localparam logic [BUS_AW-1:0] OFS_CE_FLAG  = 6'h20;
    localparam logic [BUS_AW-1:0] OFS_CE_SET   = 6'h22;
    localparam logic [BUS_AW-1:0] OFS_CE_CLR   = 6'h24;
    localparam logic [BUS_AW-1:0] OFS_CE_ACPU  = 6'h26;
    localparam logic [BUS_AW-1:0] OFS_CE_ADMA  = 6'h28;
    localparam logic [BUS_AW-1:0] OFS_CNT      = 6'h30;
    localparam logic [BUS_AW-1:0] OFS_THR      = 6'h32;
    localparam logic [BUS_AW-1:0] OFS_IFLAG    = 6'h34;
    localparam logic [BUS_AW-1:0] OFS_ICLR     = 6'h36;
    localparam logic [BUS_AW-1:0] OFS_ISET     = 6'h38;
    localparam logic [BUS_AW-1:0] OFS_IEN      = 6'h3A;

    typedef struct packed {
        logic              vld;
        logic              unc;
        logic [ERR_AW-1:0] addr;
    } err_evt_t;

    typedef struct packed {
        logic [REQ_N-1:0] set;
        logic [REQ_N-1:0] clr;
    } flag_cmd_t;

    function automatic logic [REG_W-1:0] pad_flags(input logic [REQ_N-1:0] f);
        logic [REG_W-1:0] r;
        r = '0;
        r[REQ_N-1:0] = f;
        return r;
    endfunction

endpackage

// File: rtl/mem_err_class.sv
module mem_err_class
    import mem_err_pkg::*;
#(
    parameter bit MATCH_UNC = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  err_evt_t [REQ_N-1:0]          evt,
    input  flag_cmd_t                     cmd,
    output logic [REQ_N-1:0]              flags,
    output logic [REQ_N-1:0][ERR_AW-1:0]  cap_addr,
    output logic [REQ_N-1:0]              hits
);

    for (genvar r = 0; r < REQ_N; r++) begin : g_req
        assign hits[r] = evt[r].vld && (evt[r].unc == MATCH_UNC);

        always_ff @(posedge clk) begin
            if (rst) begin
                cap_addr[r] <= '0;
            end else if (hits[r]) begin
                cap_addr[r] <= evt[r].addr;
            end
        end
    end

    // Hardware hit wins over a software clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~cmd.clr) | cmd.set | hits;
        end
    end

endmodule

// File: rtl/mem_err_cnt.sv
module mem_err_cnt
    import mem_err_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REQ_N-1:0]  hits,
    input  logic [THR_W-1:0]  thr,
    input  logic              sw_set,
    input  logic              sw_clr,
    output logic [CNT_W-1:0]  cnt,
    output logic              int_flag
);

    localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] cnt_nxt;
    logic             reach;

    always_comb begin
        sum     = {1'b0, cnt} + (CNT_W+1)'($countones(hits));
        cnt_nxt = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
        reach   = (|hits) && (CMP_W'(cnt_nxt) >= CMP_W'(thr));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            int_flag <= 1'b0;
        end else begin
            cnt      <= cnt_nxt;
            int_flag <= (int_flag & ~sw_clr) | sw_set | reach;
        end
    end

endmodule

// File: rtl/mem_err_agg.sv
module mem_err_agg
    import mem_err_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [5:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              wr_unlock,
    input  logic              cpu_err_vld,
    input  logic              cpu_err_unc,
    input  logic [31:0]       cpu_err_addr,
    input  logic              dma_err_vld,
    input  logic              dma_err_unc,
    input  logic [31:0]       dma_err_addr,
    output logic              ce_irq
);

    err_evt_t [REQ_N-1:0]             evt;
    flag_cmd_t                        uc_cmd, ce_cmd;
    logic [REQ_N-1:0]                 uc_flags, ce_flags, uc_hits, ce_hits;
    logic [REQ_N-1:0][ERR_AW-1:0]     uc_addr, ce_addr;
    logic [CNT_W-1:0]                 ce_count;
    logic                             ce_int_flag;
    logic [THR_W-1:0]                 thr_q;
    logic                             ien_q;
    logic                             wr_open, wr_prot;
    logic                             isel_set, isel_clr;

    assign evt[REQ_CPU] = '{vld: cpu_err_vld, unc: cpu_err_unc, addr: cpu_err_addr};
    assign evt[REQ_DMA] = '{vld: dma_err_vld, unc: dma_err_unc, addr: dma_err_addr};

    assign wr_open = bus_wr;
    assign wr_prot = bus_wr && wr_unlock;

    always_comb begin
        uc_cmd.set = (wr_prot && bus_addr == OFS_UC_SET) ? bus_wdata[REQ_N-1:0] : '0;
        uc_cmd.clr = (wr_prot && bus_addr == OFS_UC_CLR) ? bus_wdata[REQ_N-1:0] : '0;
        ce_cmd.set = (wr_open && bus_addr == OFS_CE_SET) ? bus_wdata[REQ_N-1:0] : '0;
        ce_cmd.clr = (wr_open && bus_addr == OFS_CE_CLR) ? bus_wdata[REQ_N-1:0] : '0;
        isel_set   = wr_prot && bus_addr == OFS_ISET && bus_wdata[0];
        isel_clr   = wr_prot && bus_addr == OFS_ICLR && bus_wdata[0];
    end

    mem_err_class #(.MATCH_UNC(1'b1)) u_unc (
        .clk(clk), .rst(rst), .evt(evt), .cmd(uc_cmd),
        .flags(uc_flags), .cap_addr(uc_addr), .hits(uc_hits)
    );

    mem_err_class #(.MATCH_UNC(1'b0)) u_cor (
        .clk(clk), .rst(rst), .evt(evt), .cmd(ce_cmd),
        .flags(ce_flags), .cap_addr(ce_addr), .hits(ce_hits)
    );

    mem_err_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .hits(ce_hits), .thr(thr_q),
        .sw_set(isel_set), .sw_clr(isel_clr),
        .cnt(ce_count), .int_flag(ce_int_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
            ien_q <= 1'b0;
        end else begin
            if (wr_prot && bus_addr == OFS_THR) thr_q <= bus_wdata[THR_W-1:0];
            if (wr_prot && bus_addr == OFS_IEN) ien_q <= bus_wdata[0];
        end
    end

    assign ce_irq = ce_int_flag & ien_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_UC_FLAG: bus_rdata = pad_flags(uc_flags);
                OFS_UC_ACPU: bus_rdata = uc_addr[REQ_CPU];
                OFS_UC_ADMA: bus_rdata = uc_addr[REQ_DMA];
                OFS_CE_FLAG: bus_rdata = pad_flags(ce_flags);
                OFS_CE_ACPU: bus_rdata = ce_addr[REQ_CPU];
                OFS_CE_ADMA: bus_rdata = ce_addr[REQ_DMA];
                OFS_CNT:     bus_rdata = REG_W'(ce_count);
                OFS_THR:     bus_rdata = REG_W'(thr_q);
                OFS_IFLAG:   bus_rdata = REG_W'(ce_int_flag);
                OFS_IEN:     bus_rdata = REG_W'(ien_q);
                default:     bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mem_err_agg_chk.sv
module mem_err_agg_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [5:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             wr_unlock,
    input logic             cpu_err_vld,
    input logic             cpu_err_unc,
    input logic [31:0]      cpu_err_addr,
    input logic             dma_err_vld,
    input logic             dma_err_unc,
    input logic [CNT_W-1:0] cnt,
    input logic             int_flag,
    input logic [1:0]       ce_flags,
    input logic [31:0]      uc_cpu_addr
);

    // R4
    cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cnt >= $past(cnt));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt - $past(cnt)) <= CNT_W'(2));

    // R1
    ce_cpu_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_err_vld && !cpu_err_unc) |=> ce_flags[0]);

    // R10
    ce_dma_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_err_vld && !dma_err_unc && bus_wr && bus_addr == 6'h24) |=> ce_flags[1]);

    // R3
    uc_cpu_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_err_vld && cpu_err_unc) |=> uc_cpu_addr == $past(cpu_err_addr));

    // R6
    iflag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_flag) |-> $past((cpu_err_vld && !cpu_err_unc) ||
                                  (dma_err_vld && !dma_err_unc) ||
                                  (bus_wr && wr_unlock && bus_addr == 6'h38 && bus_wdata[0])));

    // R9
    rsvd_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 6'h0C) |-> bus_rdata == 32'h0);

endmodule

bind mem_err_agg mem_err_agg_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wr_unlock(wr_unlock), .cpu_err_vld(cpu_err_vld), .cpu_err_unc(cpu_err_unc),
    .cpu_err_addr(cpu_err_addr), .dma_err_vld(dma_err_vld), .dma_err_unc(dma_err_unc),
    .cnt(ce_count), .int_flag(ce_int_flag), .ce_flags(ce_flags),
    .uc_cpu_addr(uc_addr[0])
);

// File: tb/mem_err_agg_tb.sv
`timescale 1ns/1ps
module mem_err_agg_tb;

    localparam int CW  = 8;
    localparam int CMAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 0, bus_wr = 0, wr_unlock = 0;
    logic [5:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        cpu_err_vld = 0, cpu_err_unc = 0, dma_err_vld = 0, dma_err_unc = 0;
    logic [31:0] cpu_err_addr = 0, dma_err_addr = 0;
    logic        ce_irq;

    int checks = 0, failures = 0;

    // bench model
    logic [1:0]  m_uc, m_ce;
    logic [31:0] m_ua_c, m_ua_d, m_ca_c, m_ca_d;
    int          m_cnt;
    logic [15:0] m_thr;
    logic        m_if, m_en;

    always #4 clk = ~clk;

    mem_err_agg #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wr_unlock(wr_unlock),
        .cpu_err_vld(cpu_err_vld), .cpu_err_unc(cpu_err_unc), .cpu_err_addr(cpu_err_addr),
        .dma_err_vld(dma_err_vld), .dma_err_unc(dma_err_unc), .dma_err_addr(dma_err_addr),
        .ce_irq(ce_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        case (a)
            6'h00: return {30'b0, m_uc};
            6'h06: return m_ua_c;
            6'h08: return m_ua_d;
            6'h20: return {30'b0, m_ce};
            6'h26: return m_ca_c;
            6'h28: return m_ca_d;
            6'h30: return 32'(m_cnt);
            6'h32: return {16'b0, m_thr};
            6'h34: return {31'b0, m_if};
            6'h3A: return {31'b0, m_en};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        m_uc = 0; m_ce = 0; m_ua_c = 0; m_ua_d = 0; m_ca_c = 0; m_ca_d = 0;
        m_cnt = 0; m_thr = 0; m_if = 0; m_en = 0;
    endtask

    // one clock cycle with the given stimulus; model updated after the edge
    task automatic step(input logic cv, input logic cu, input logic [31:0] ca,
                        input logic dv, input logic du, input logic [31:0] da,
                        input logic wr, input logic [5:0] wa, input logic [31:0] wd,
                        input logic unl);
        int n;
        logic [1:0] uh, chh, s, c;
        logic hit;
        @(negedge clk);
        cpu_err_vld = cv; cpu_err_unc = cu; cpu_err_addr = ca;
        dma_err_vld = dv; dma_err_unc = du; dma_err_addr = da;
        bus_wr = wr; bus_addr = wa; bus_wdata = wd; wr_unlock = unl;
        @(posedge clk);
        uh  = {dv && du, cv && cu};
        chh = {dv && !du, cv && !cu};
        s = (wr && unl && wa == 6'h02) ? wd[1:0] : 2'b0;
        c = (wr && unl && wa == 6'h04) ? wd[1:0] : 2'b0;
        m_uc = (m_uc & ~c) | s | uh;
        s = (wr && wa == 6'h22) ? wd[1:0] : 2'b0;
        c = (wr && wa == 6'h24) ? wd[1:0] : 2'b0;
        m_ce = (m_ce & ~c) | s | chh;
        if (uh[0])  m_ua_c = ca;
        if (uh[1])  m_ua_d = da;
        if (chh[0]) m_ca_c = ca;
        if (chh[1]) m_ca_d = da;
        n = int'(chh[0]) + int'(chh[1]);
        m_cnt = (m_cnt + n > CMAX) ? CMAX : m_cnt + n;
        hit = (n != 0) && (m_cnt >= int'(m_thr));
        m_if = (m_if & ~(wr && unl && wa == 6'h36 && wd[0]))
             | (wr && unl && wa == 6'h38 && wd[0]) | hit;
        if (wr && unl && wa == 6'h32) m_thr = wd[15:0];
        if (wr && unl && wa == 6'h3A) m_en = wd[0];
        #1;
        cpu_err_vld = 0; dma_err_vld = 0; bus_wr = 0;
        check("R7 ce_irq", {31'b0, ce_irq}, {31'b0, m_if & m_en});
    endtask

    task automatic idle(); step(0,0,0, 0,0,0, 0,0,0, 0); endtask
    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic unl);
        step(0,0,0, 0,0,0, 1,a,d, unl);
    endtask

    task automatic rd(input string req, input logic [5:0] a);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1;
        check(req, bus_rdata, exp_rd(a));
        bus_rd = 0;
    endtask

    task automatic rd_all(input string req);
        logic [5:0] ofs [16] = '{6'h00,6'h02,6'h04,6'h06,6'h08,6'h20,6'h22,6'h24,
                                 6'h26,6'h28,6'h30,6'h32,6'h34,6'h36,6'h38,6'h3A};
        for (int i = 0; i < 16; i++) rd(req, ofs[i]);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 0;

        // R9 reset state
        rd_all("R9 reset");

        // R8 locked threshold write ignored, R5 upper bits dropped
        wr(6'h32, 32'h0000_0005, 0);
        rd("R8 thr locked", 6'h32);
        wr(6'h32, 32'hABCD_0005, 1);
        rd("R5 thr upper zero", 6'h32);

        // R1 R3 R4 single cpu correctable
        step(1,0,32'h1000_0040, 0,0,0, 0,0,0, 0);
        rd("R1 ce flag", 6'h20); rd("R3 ce cpu addr", 6'h26); rd("R4 count one", 6'h30);

        // R4 two correctable events in one cycle
        step(1,0,32'h2000_0010, 1,0,32'h3000_0020, 0,0,0, 0);
        rd("R4 count two", 6'h30); rd("R3 ce dma addr", 6'h28);
        rd("R6 below thr", 6'h34);

        // R6 reach threshold 5 exactly (>=)
        step(1,0,32'h44, 0,0,0, 0,0,0, 0);
        rd("R6 at four", 6'h34);
        step(0,0,0, 1,0,32'h55, 0,0,0, 0);
        rd("R6 at five", 6'h34);

        // R7 enable
        wr(6'h3A, 32'h1, 1);
        rd("R7 enable", 6'h3A);

        // R8 locked clear ignored, unlocked clear works
        wr(6'h36, 32'h1, 0);
        rd("R8 iclr locked", 6'h34);
        wr(6'h36, 32'h1, 1);
        rd("R6 iclr", 6'h34);
        // R6 event beats clear
        step(1,0,32'h66, 0,0,0, 1,6'h36,32'h1, 1);
        rd("R6 event over clear", 6'h34);
        wr(6'h36, 32'h1, 1);
        wr(6'h38, 32'h1, 1);
        rd("R6 iset", 6'h34);

        // R10 ce flag clear same cycle as event
        step(0,0,0, 1,0,32'h77, 1,6'h24,32'h3, 0);
        rd("R10 prio", 6'h20);
        // R2 ce clear not gated
        wr(6'h24, 32'h3, 0);
        rd("R2 ce clear", 6'h20);
        wr(6'h22, 32'hFFFF_FFFE, 0);
        rd("R2 ce set", 6'h20); rd("R2 set reads 0", 6'h22);

        // R8 R2 uncorrectable set/clear gated
        wr(6'h02, 32'h3, 0);
        rd("R8 uc set locked", 6'h00);
        wr(6'h02, 32'h3, 1);
        rd("R2 uc set", 6'h00);
        wr(6'h04, 32'h1, 1);
        rd("R2 uc clear", 6'h00);
        step(1,1,32'hDEAD_0000, 1,1,32'hBEEF_0004, 0,0,0, 0);
        rd("R1 uc flags", 6'h00); rd("R3 uc cpu", 6'h06); rd("R3 uc dma", 6'h08);
        rd("R4 unc not counted", 6'h30);

        // R9 unlisted offset ignores writes
        wr(6'h0C, 32'hFFFF_FFFF, 1);
        rd("R9 unlisted", 6'h0C);
        rd_all("R9 no side effect");

        // R11 no read strobe
        @(negedge clk); bus_addr = 6'h06; #1;
        check("R11 idle rdata", bus_rdata, 32'h0);

        // R4 saturation
        for (int i = 0; i < 140; i++) step(1,0,32'(i), 1,0,32'(i+7), 0,0,0, 0);
        rd("R4 saturate", 6'h30);

        // random phase
        wr(6'h36, 32'h1, 1);
        for (int i = 0; i < 600; i++) begin
            logic [5:0] ofs [10] = '{6'h02,6'h04,6'h22,6'h24,6'h32,6'h36,6'h38,6'h3A,6'h30,6'h10};
            logic w;
            w = ($urandom % 4) == 0;
            step(($urandom % 3) == 0, $urandom % 2, $urandom,
                 ($urandom % 3) == 0, $urandom % 2, $urandom,
                 w, ofs[$urandom % 10], ($urandom % 2) ? 32'(($urandom % 3) + 1) : $urandom,
                 $urandom % 2);
            if (i % 50 == 49) rd_all("R1 R6 random readback");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule